// File: doc/BRIEF.md
# Deflection Router Output Allocator

Each cycle this block assigns an output port to every flit held in the four neighbour input registers of a router in a 2-D mesh. There are no buffers. A flit that is registered in one cycle must leave through some output during the next evaluation. Flits are served in order of the hops they have already taken, so the flit that has travelled furthest chooses first. Each flit tries a direction that brings it closer to its destination. If those directions are taken, it is deflected to the free mesh port whose neighbour reports the lowest recent load.

A flit addressed to this node is ejected through a single local port. The local port also admits one injected flit when a mesh output is certain to be free. Every forwarded flit leaves with its hop field advanced by one. On the mesh edge, the outputs that face off the mesh are wired back to the same router's inputs outside this block. All four mesh outputs therefore remain usable at every node position. The neighbour load values (packets processed over the last four cycles) arrive as inputs.

Top module: `defl_port_alloc`

## Requirements
- R1: A flit presented with its valid bit is captured at a rising edge and offered for allocation during the following cycle only. If no new flit arrives, the port is empty after the next edge.
- R2: Every registered flit, and an accepted injected flit, leaves on exactly one output in the cycle it is offered. The number of valid outputs equals the number of such flits.
- R3: No output carries more than one flit in a cycle.
- R4: Flits choose in descending hop-count order. Equal hop counts are ordered by input index: N (0), E (1), S (2), W (3). The injected flit chooses last.
- R5: A flit first tries its X direction and then its Y direction, using only directions that shorten the distance. E (index 1) moves to x+1 and W (index 3) to x-1. N (index 0) moves to y+1 and S (index 2) to y-1. Destinations are packed {x, y}, with x in the upper half.
- R6: A flit with no free productive direction is deflected to the free mesh output with the smallest stress value. Ties go to the lowest index.
- R7: A flit whose destination equals (my_x, my_y) leaves on the local output, index 4, when that output is free. Only such flits ever use it. A second flit for this node in the same cycle is deflected.
- R8: Each output flit carries its hop count plus one, saturating at the all-ones value. An injected flit leaves with hop count 1.
- R9: inj_ready is high exactly when fewer than four mesh flits are registered. An injected flit is routed only when inj_valid and inj_ready are both high.
- R10: All four mesh outputs may be used for deflection at any node position, including the corner (0,0).
- R11: An asynchronous active-low reset empties all input registers. After reset no output is valid and inj_ready is high.
- R12: Fields of an output that carries no flit read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_x | input | CW | X coordinate of this node |
| my_y | input | CW | Y coordinate of this node |
| in_valid | input | 4 | Flit present per neighbour input (N,E,S,W = bits 0..3) |
| in_dest | input | 4*2*CW | Destination {x,y} per input |
| in_hop | input | 4*HW | Hop count per input |
| in_data | input | 4*DW | Payload per input |
| stress | input | 4*SW | Recent load of each neighbour |
| inj_valid | input | 1 | Local flit waiting to enter |
| inj_dest | input | 2*CW | Destination {x,y} of the local flit |
| inj_data | input | DW | Payload of the local flit |
| inj_ready | output | 1 | Local flit is taken this cycle when valid |
| out_valid | output | 5 | Flit present per output (N,E,S,W,local = bits 0..4) |
| out_dest | output | 5*2*CW | Destination per output |
| out_hop | output | 5*HW | Advanced hop count per output |
| out_data | output | 5*DW | Payload per output |

## Verification
On every cycle, the bound properties check the following:
- flit conservation;
- that no output column holds two grants;
- that each registered flit holds exactly one grant;
- that the input register follows its valid bit;
- that ejected flits are addressed here;
- that the injection gate closes when all four inputs are full.

Only the bench scenarios can show which flit wins a contended port, that X is tried before Y, that the deflection target is the least stressed free port, and that the hop count saturates. These outcomes depend on hand-derived expectations for specific traffic patterns, not on a per-cycle invariant.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  // mesh directions, then the local port
  localparam int NDIR = 4;
  localparam int NOUT = NDIR + 1;
  localparam int NREQ = NDIR + 1;
  localparam int P_N  = 0;
  localparam int P_E  = 1;
  localparam int P_S  = 2;
  localparam int P_W  = 3;
  localparam int P_L  = 4;
endpackage

// File: rtl/dpa_in_reg.sv
module dpa_in_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [W-1:0] d_flit,
  output logic         q_valid,
  output logic [W-1:0] q_flit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_flit  <= '0;
    end else begin
      q_valid <= d_valid;
      q_flit  <= d_flit;
    end
  end
endmodule

// File: rtl/dpa_rank.sv
module dpa_rank #(
  parameter int N  = 4,
  parameter int HW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    valid,
  input  logic [N*HW-1:0] hop,
  output logic [N*IW-1:0] order
);
  logic [IW-1:0] rank [N];

  // j is served before i: valid first, then larger hop, then lower index
  function automatic logic ahead(input logic vj, input logic [HW-1:0] hj, input int j,
                                 input logic vi, input logic [HW-1:0] hi, input int i);
    logic [HW:0] kj, ki;
    kj = {vj, hj};
    ki = {vi, hi};
    return (kj > ki) || ((kj == ki) && (j < i));
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < N; j++) begin
        if (j != i && ahead(valid[j], hop[j*HW +: HW], j, valid[i], hop[i*HW +: HW], i))
          cnt++;
      end
      rank[i] = IW'(cnt);
    end
  end

  always_comb begin
    order = '0;
    for (int r = 0; r < N; r++) begin
      for (int i = 0; i < N; i++) begin
        if (rank[i] == IW'(r)) order[r*IW +: IW] = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dpa_assign.sv
module dpa_assign
  import dpa_pkg::*;
#(
  parameter int CW = 3,
  parameter int SW = 3,
  localparam int IW = $clog2(NDIR)
) (
  input  logic [CW-1:0]        my_x,
  input  logic [CW-1:0]        my_y,
  input  logic [NDIR-1:0]      valid,
  input  logic [NDIR*2*CW-1:0] dest,
  input  logic [NDIR*IW-1:0]   order,
  input  logic [NDIR*SW-1:0]   stress,
  input  logic                 inj_valid,
  input  logic [2*CW-1:0]      inj_dest,
  output logic [NREQ*NOUT-1:0] route_oh,
  output logic                 inj_ready
);
  // four mesh flits always fit in four mesh ports; a fifth may not
  assign inj_ready = ~&valid;

  function automatic logic [NOUT-1:0] pick(input logic [2*CW-1:0] d, input logic [NOUT-1:0] busy,
                                           input logic [CW-1:0] mx, input logic [CW-1:0] my,
                                           input logic [NDIR*SW-1:0] st);
    logic [CW-1:0] dx, dy;
    logic [SW-1:0] best;
    logic          found;
    int            sel;
    dx = d[2*CW-1:CW];
    dy = d[CW-1:0];
    pick  = '0;
    best  = '0;
    found = 1'b0;
    sel   = 0;
    if (dx == mx && dy == my && !busy[P_L])  pick[P_L] = 1'b1;
    else if (dx > mx && !busy[P_E])          pick[P_E] = 1'b1;
    else if (dx < mx && !busy[P_W])          pick[P_W] = 1'b1;
    else if (dy > my && !busy[P_N])          pick[P_N] = 1'b1;
    else if (dy < my && !busy[P_S])          pick[P_S] = 1'b1;
    else begin
      for (int p = 0; p < NDIR; p++) begin
        if (!busy[p] && (!found || st[p*SW +: SW] < best)) begin
          found = 1'b1;
          best  = st[p*SW +: SW];
          sel   = p;
        end
      end
      pick[sel] = 1'b1;
    end
  endfunction

  always_comb begin
    logic [NOUT-1:0] busy;
    logic [NOUT-1:0] sel;
    logic [IW-1:0]   idx;
    busy     = '0;
    route_oh = '0;
    for (int r = 0; r < NDIR; r++) begin
      idx = order[r*IW +: IW];
      sel = '0;
      if (valid[idx]) sel = pick(dest[idx*2*CW +: 2*CW], busy, my_x, my_y, stress);
      route_oh[idx*NOUT +: NOUT] = sel;
      busy = busy | sel;
    end
    if (inj_valid && inj_ready)
      route_oh[NDIR*NOUT +: NOUT] = pick(inj_dest, busy, my_x, my_y, stress);
  end
endmodule

// File: rtl/defl_port_alloc.sv
module defl_port_alloc
  import dpa_pkg::*;
#(
  parameter int CW = 3,
  parameter int HW = 4,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        my_x,
  input  logic [CW-1:0]        my_y,
  input  logic [NDIR-1:0]      in_valid,
  input  logic [NDIR*2*CW-1:0] in_dest,
  input  logic [NDIR*HW-1:0]   in_hop,
  input  logic [NDIR*DW-1:0]   in_data,
  input  logic [NDIR*SW-1:0]   stress,
  input  logic                 inj_valid,
  input  logic [2*CW-1:0]      inj_dest,
  input  logic [DW-1:0]        inj_data,
  output logic                 inj_ready,
  output logic [NOUT-1:0]      out_valid,
  output logic [NOUT*2*CW-1:0] out_dest,
  output logic [NOUT*HW-1:0]   out_hop,
  output logic [NOUT*DW-1:0]   out_data
);
  localparam int FW = 2*CW + HW + DW;
  localparam int IW = $clog2(NDIR);

  logic [NDIR-1:0]      q_valid;
  logic [NDIR*FW-1:0]   q_flit;
  logic [NDIR*2*CW-1:0] q_dest;
  logic [NDIR*HW-1:0]   q_hop;
  logic [NDIR*DW-1:0]   q_data;
  logic [NDIR*IW-1:0]   order;
  logic [NREQ*NOUT-1:0] route_oh;
  logic [NREQ*2*CW-1:0] r_dest;
  logic [NREQ*HW-1:0]   r_hop;
  logic [NREQ*DW-1:0]   r_data;

  function automatic logic [HW-1:0] hop_step(input logic [HW-1:0] h);
    return (&h) ? h : h + 1'b1;
  endfunction

  for (genvar i = 0; i < NDIR; i++) begin : g_port
    dpa_in_reg #(.W(FW)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid[i]),
      .d_flit  ({in_dest[i*2*CW +: 2*CW], in_hop[i*HW +: HW], in_data[i*DW +: DW]}),
      .q_valid (q_valid[i]),
      .q_flit  (q_flit[i*FW +: FW])
    );
    assign {q_dest[i*2*CW +: 2*CW], q_hop[i*HW +: HW], q_data[i*DW +: DW]} = q_flit[i*FW +: FW];
  end

  dpa_rank #(.N(NDIR), .HW(HW)) u_rank (
    .valid (q_valid),
    .hop   (q_hop),
    .order (order)
  );

  dpa_assign #(.CW(CW), .SW(SW)) u_assign (
    .my_x      (my_x),
    .my_y      (my_y),
    .valid     (q_valid),
    .dest      (q_dest),
    .order     (order),
    .stress    (stress),
    .inj_valid (inj_valid),
    .inj_dest  (inj_dest),
    .route_oh  (route_oh),
    .inj_ready (inj_ready)
  );

  // requester NDIR is the local injection, entering with zero hops
  assign r_dest = {inj_dest, q_dest};
  assign r_hop  = {{HW{1'b0}}, q_hop};
  assign r_data = {inj_data, q_data};

  always_comb begin
    out_valid = '0;
    out_dest  = '0;
    out_hop   = '0;
    out_data  = '0;
    for (int p = 0; p < NOUT; p++) begin
      for (int k = 0; k < NREQ; k++) begin
        if (route_oh[k*NOUT + p]) begin
          out_valid[p]              = 1'b1;
          out_dest[p*2*CW +: 2*CW]  = r_dest[k*2*CW +: 2*CW];
          out_hop[p*HW +: HW]       = hop_step(r_hop[k*HW +: HW]);
          out_data[p*DW +: DW]      = r_data[k*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker
  import dpa_pkg::*;
#(
  parameter int CW = 3,
  parameter int HW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CW-1:0]        my_x,
  input logic [CW-1:0]        my_y,
  input logic [NDIR-1:0]      in_valid,
  input logic [NDIR-1:0]      q_valid,
  input logic [NREQ*NOUT-1:0] route_oh,
  input logic                 inj_valid,
  input logic                 inj_ready,
  input logic [NOUT-1:0]      out_valid,
  input logic [NOUT*2*CW-1:0] out_dest,
  input logic [NOUT*HW-1:0]   out_hop
);
  logic [NREQ-1:0] col [NOUT];

  always_comb begin
    for (int p = 0; p < NOUT; p++)
      for (int k = 0; k < NREQ; k++)
        col[p][k] = route_oh[k*NOUT + p];
  end

  for (genvar p = 0; p < NOUT; p++) begin : g_out
    // R3
    one_flit_per_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[p]));
    // R8
    hop_advanced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[p] |-> (out_hop[p*HW +: HW] != '0));
  end

  for (genvar k = 0; k < NDIR; k++) begin : g_in
    // R2
    flit_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid[k] |-> ($countones(route_oh[k*NOUT +: NOUT]) == 1));
    // R1
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[k] |=> q_valid[k]);
    // R1
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid[k] |=> !q_valid[k]);
  end

  // R2
  conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(q_valid) + ((inj_valid && inj_ready) ? 1 : 0));
  // R7
  eject_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[P_L] |-> (out_dest[P_L*2*CW +: 2*CW] == {my_x, my_y}));
  // R9
  inj_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&q_valid) |-> !inj_ready);
endmodule

bind defl_port_alloc dpa_checker #(.CW(CW), .HW(HW)) u_dpa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .my_x      (my_x),
  .my_y      (my_y),
  .in_valid  (in_valid),
  .q_valid   (q_valid),
  .route_oh  (route_oh),
  .inj_valid (inj_valid),
  .inj_ready (inj_ready),
  .out_valid (out_valid),
  .out_dest  (out_dest),
  .out_hop   (out_hop)
);

// File: tb/test_defl_port_alloc.sv
`timescale 1ns/1ps
module test_defl_port_alloc;
  localparam int CW = 3, HW = 4, DW = 8, SW = 3;

  typedef struct packed {
    logic [23:0] req;
    logic [2:0]  mx, my;
    logic [3:0]  vld;               // {W,S,E,N}
    logic [5:0]  dn, de, ds, dw;    // {x,y}
    logic [3:0]  hn, he, hs, hw;
    logic [2:0]  sn, se, ss, sw;
    logic        iv;
    logic [5:0]  idst;
    logic        rdy;
    logic [7:0]  en, ee, es, ew, el; // expected tag per output, 0 = empty
  } vec_t;

  // tags: N=10 E=20 S=30 W=40 inject=50
  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{"R5 ",3'd2,3'd2,4'b0001, 6'o42,6'o00,6'o00,6'o00, 4'd1,4'd0,4'd0,4'd0, 3'd0,3'd0,3'd0,3'd0,
      1'b0,6'o00,1'b1, 8'h00,8'h10,8'h00,8'h00,8'h00},
    '{"R4 ",3'd2,3'd2,4'b0011, 6'o44,6'o41,6'o00,6'o00, 4'd3,4'd1,4'd0,4'd0, 3'd0,3'd0,3'd0,3'd0,
      1'b0,6'o00,1'b1, 8'h00,8'h10,8'h20,8'h00,8'h00},
    '{"R6 ",3'd2,3'd2,4'b1001, 6'o32,6'o00,6'o00,6'o32, 4'd2,4'd0,4'd0,4'd2, 3'd3,3'd0,3'd1,3'd2,
      1'b0,6'o00,1'b1, 8'h00,8'h10,8'h40,8'h00,8'h00},
    '{"R4 ",3'd2,3'd2,4'b1001, 6'o32,6'o00,6'o00,6'o32, 4'd2,4'd0,4'd0,4'd5, 3'd3,3'd0,3'd1,3'd2,
      1'b0,6'o00,1'b1, 8'h00,8'h40,8'h10,8'h00,8'h00},
    '{"R7 ",3'd2,3'd2,4'b0110, 6'o00,6'o22,6'o22,6'o00, 4'd0,4'd4,4'd0,4'd0, 3'd2,3'd0,3'd2,3'd0,
      1'b0,6'o00,1'b1, 8'h00,8'h30,8'h00,8'h00,8'h20},
    '{"R10",3'd0,3'd0,4'b1111, 6'o00,6'o10,6'o10,6'o01, 4'd7,4'd6,4'd6,4'd1, 3'd0,3'd0,3'd0,3'd0,
      1'b1,6'o11,1'b0, 8'h30,8'h20,8'h40,8'h00,8'h10},
    '{"R9 ",3'd2,3'd2,4'b0000, 6'o00,6'o00,6'o00,6'o00, 4'd0,4'd0,4'd0,4'd0, 3'd0,3'd0,3'd0,3'd0,
      1'b1,6'o23,1'b1, 8'h50,8'h00,8'h00,8'h00,8'h00},
    '{"R9 ",3'd2,3'd2,4'b1000, 6'o00,6'o00,6'o00,6'o02, 4'd0,4'd0,4'd0,4'd2, 3'd4,3'd4,3'd0,3'd0,
      1'b1,6'o02,1'b1, 8'h00,8'h00,8'h50,8'h40,8'h00},
    '{"R5 ",3'd2,3'd2,4'b0100, 6'o00,6'o00,6'o00,6'o00, 4'd0,4'd0,4'd0,4'd0, 3'd0,3'd0,3'd0,3'd0,
      1'b1,6'o33,1'b1, 8'h00,8'h50,8'h00,8'h30,8'h00}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CW-1:0]     my_x = '0, my_y = '0;
  logic [3:0]        in_valid = '0;
  logic [4*2*CW-1:0] in_dest = '0;
  logic [4*HW-1:0]   in_hop = '0;
  logic [4*DW-1:0]   in_data = '0;
  logic [4*SW-1:0]   stress = '0;
  logic              inj_valid = 1'b0;
  logic [2*CW-1:0]   inj_dest = '0;
  logic [DW-1:0]     inj_data = '0;
  logic              inj_ready;
  logic [4:0]        out_valid;
  logic [5*2*CW-1:0] out_dest;
  logic [5*HW-1:0]   out_hop;
  logic [5*DW-1:0]   out_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  defl_port_alloc #(.CW(CW), .HW(HW), .DW(DW), .SW(SW)) i_defl_port_alloc (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .in_valid(in_valid), .in_dest(in_dest), .in_hop(in_hop), .in_data(in_data),
    .stress(stress), .inj_valid(inj_valid), .inj_dest(inj_dest), .inj_data(inj_data),
    .inj_ready(inj_ready), .out_valid(out_valid), .out_dest(out_dest),
    .out_hop(out_hop), .out_data(out_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int hop_of(input vec_t v, input logic [7:0] tag);
    case (tag)
      8'h10: return (v.hn == 4'hF) ? 15 : v.hn + 1;
      8'h20: return (v.he == 4'hF) ? 15 : v.he + 1;
      8'h30: return (v.hs == 4'hF) ? 15 : v.hs + 1;
      8'h40: return (v.hw == 4'hF) ? 15 : v.hw + 1;
      default: return 1;
    endcase
  endfunction

  // called at a falling edge; checks at the next falling edge
  task automatic apply(input vec_t v);
    logic [7:0] exp [5];
    logic [7:0] src [5];
    string r;
    int nexp;
    r = string'(v.req);
    my_x = v.mx; my_y = v.my;
    in_valid  = v.vld;
    in_dest   = {v.dw, v.ds, v.de, v.dn};
    in_hop    = {v.hw, v.hs, v.he, v.hn};
    in_data   = {8'h40, 8'h30, 8'h20, 8'h10};
    stress    = {v.sw, v.ss, v.se, v.sn};
    inj_valid = v.iv; inj_dest = v.idst; inj_data = 8'h50;
    @(posedge clk);
    @(negedge clk);
    exp = '{v.en, v.ee, v.es, v.ew, v.el};
    chk(r, "inj_ready", int'(inj_ready), int'(v.rdy));
    for (int p = 0; p < 5; p++) begin
      chk(r, $sformatf("out_valid[%0d]", p), int'(out_valid[p]), int'(exp[p] != 8'h00));
      chk(r, $sformatf("out_data[%0d]", p), int'(out_data[p*DW +: DW]), int'(exp[p]));
      if (exp[p] != 8'h00)
        chk(r, $sformatf("out_hop[%0d]", p), int'(out_hop[p*HW +: HW]), hop_of(v, exp[p]));
      else // R12
        chk("R12", $sformatf("out_hop[%0d]", p), int'(out_hop[p*HW +: HW]), 0);
    end
    // R2: output count equals flits offered
    nexp = $countones(v.vld) + ((v.iv && v.rdy) ? 1 : 0);
    chk("R2", "valid output count", $countones(out_valid), nexp);
    // R3: every offered flit seen on exactly one output
    src = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
    for (int s = 0; s < 5; s++) begin
      bit offered;
      int seen;
      offered = (s < 4) ? v.vld[s] : (v.iv && v.rdy);
      seen = 0;
      for (int p = 0; p < 5; p++)
        if (out_valid[p] && out_data[p*DW +: DW] == src[s]) seen++;
      chk("R3", $sformatf("copies of %0h", src[s]), seen, offered ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: state held in reset
    chk("R11", "out_valid in reset", int'(out_valid), 0);
    chk("R11", "inj_ready in reset", int'(inj_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid after reset", int'(out_valid), 0);

    for (int n = 0; n < NV; n++) apply(VT[n]);

    // R8: saturation of the hop field
    v = '0; v.req = "R8 "; v.mx = 3'd2; v.my = 3'd2; v.vld = 4'b0001;
    v.dn = 6'o32; v.hn = 4'd15; v.rdy = 1'b1; v.ee = 8'h10;
    apply(v);
    v.hn = 4'd14;
    apply(v);

    // R1: a port with no new flit is empty after the next edge
    v = '0; v.req = "R1 "; v.mx = 3'd2; v.my = 3'd2; v.rdy = 1'b1;
    apply(v);

    // R11: asynchronous reset empties registered flits
    v = '0; v.req = "R11"; v.mx = 3'd2; v.my = 3'd2; v.vld = 4'b0010;
    v.de = 6'o52; v.rdy = 1'b1; v.ee = 8'h20;
    apply(v);
    rst_n = 1'b0;
    #1;
    chk("R11", "out_valid after async reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    in_valid = '0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule